// File: doc/BRIEF.md
# Clock Frequency Offset Monitor

This block checks three monitored clocks against one reference clock and raises a separate alarm for each monitored clock whose frequency has drifted too far from its nominal value. Each monitored clock must nominally run at an integer multiple of the reference. That multiple is supplied per channel on the `ratio` input. A monitored clock is therefore valid only when both it and the reference sit on a common base rate.

The measurement uses gated cycle counting. The reference domain opens a measurement window of exactly 2^WIN_LOG2 reference cycles. In each monitored domain a free-running counter runs, and its value crosses into the reference domain in Gray code. At every window end the block takes the number of monitored edges seen in the window and compares it with `ratio × 2^WIN_LOG2`. The allowed tolerance is `ratio × TOL_TIGHT` counts when `thr_tight` is high and `ratio × TOL_LOOSE` counts when it is low. By default these are the per-window equivalents of ±4.6 ppm and ±20 ppm, for a tight stratum-class limit and a looser minimum-clock limit.

One failing window sets an alarm. Clearing it takes two consecutive passing windows. A window in which a monitored clock produced no edges at all raises the alarm at once, even in the first window after reset, where the count comparison is skipped.

Top module: `fom_monitor`

## Requirements
- R1: While `rst_n` is low, and after its release until the first window closes, every bit of `alarm` is 0.
- R2: Windows are exactly 2^WIN_LOG2 reference cycles long and follow each other back to back. An alarm can only change 2 reference cycles after a window closes, so alarm rises on different channels are separated by a multiple of 2^WIN_LOG2 reference cycles.
- R3: A monitored clock at exactly `ratio` times the reference never raises its alarm, whichever threshold class is selected.
- R4: With `thr_tight` = 0, a window whose count exceeds `ratio × 2^WIN_LOG2` by more than `ratio × TOL_LOOSE` raises the alarm, and a deviation inside that bound does not.
- R5: With `thr_tight` = 1, the bound becomes `ratio × TOL_TIGHT`. A deviation that passes the loose class therefore raises the alarm under the tight class.
- R6: The bound applies in both directions, so a monitored clock that is too slow raises the alarm just as a fast one does.
- R7: A single failing window is enough to set the alarm. The alarm rises within two windows of the frequency going wrong.
- R8: A set alarm clears only after two consecutive passing windows. After one passing window it is still set.
- R9: A window with zero monitored edges sets the alarm, including the first window after reset.
- R10: Each channel is judged on its own. A fault on one monitored clock leaves the other alarms at 0.
- R11: The monitored count crosses into the reference domain in Gray code, and the code changes by at most one bit per monitored clock edge.
- R12: Between measurements the alarm outputs hold their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside each clock domain |
| ref_clk | input | 1 | Reference clock that times the measurement windows |
| mon_clk | input | NUM_MON | Monitored clocks, one per channel |
| ratio | input | NUM_MON × RATIO_W | Nominal integer multiple of the reference for each monitored clock |
| thr_tight | input | 1 | Threshold class: 1 selects the tight bound, 0 the loose bound |
| alarm | output | NUM_MON | Frequency offset alarm per channel, in the reference domain |

## Verification
The bench builds the monitor with WIN_LOG2 = 10 and overrides the tolerances to 2 and 8 counts per unit of ratio. A window then lasts 10.24 µs, so the run can cover dozens of windows, including the set-then-clear sequence and alignment of rises across channels. With ratios 1, 2 and 3 on the three channels, an offset of 10 counts on the ratio-2 channel falls between the two classes and an offset of 30 exceeds both. Offsets this large stay clear of the ±1 count quantisation that comes from clock phase. A stopped clock at reset exercises the zero-count path in the first window.

// File: rtl/fom_pkg.sv
package fom_pkg;

  // Count tolerance per window per unit of ratio for a limit given in tenths of ppm.
  function automatic int unsigned ppm_counts(input int unsigned win_log2,
                                             input int unsigned ppm_tenths);
    longint unsigned win;
    win = longint'(1) << win_log2;
    return int'((win * longint'(ppm_tenths)) / 64'd10_000_000);
  endfunction

  localparam int unsigned TIGHT_PPM_X10 = 46;
  localparam int unsigned LOOSE_PPM_X10 = 200;

endpackage

// File: rtl/fom_rst_sync.sv
module fom_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) pipe_q <= '0;
    else         pipe_q <= pipe_d;
  end

  assign srst_n = pipe_q[STAGES-1];
endmodule

// File: rtl/fom_gray_counter.sv
module fom_gray_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] gray
);
  logic [W-1:0] bin_q, bin_d;
  logic [W-1:0] gray_q, gray_d;

  always_comb begin
    bin_d  = bin_q + 1'b1;
    gray_d = bin_d ^ (bin_d >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      bin_q  <= bin_d;
      gray_q <= gray_d;
    end
  end

  assign gray = gray_q;
endmodule

// File: rtl/fom_gray_sync.sv
module fom_gray_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
    end else begin
      stage_q[0] <= gray_in;
      for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
    end
  end

  // Gray to binary: each bit is the XOR of all gray bits at or above it.
  always_comb begin
    bin_out = '0;
    for (int k = 0; k < W; k++) bin_out = bin_out ^ (stage_q[STAGES-1] >> k);
  end
endmodule

// File: rtl/fom_window_gen.sv
module fom_window_gen #(
  parameter int unsigned WIN_LOG2 = 10
) (
  input  logic clk,
  input  logic rst_n,
  output logic win_end
);
  logic [WIN_LOG2-1:0] cnt_q, cnt_d;
  logic                end_q, end_d;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    end_d = &cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      end_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      end_q <= end_d;
    end
  end

  assign win_end = end_q;
endmodule

// File: rtl/fom_meas.sv
module fom_meas #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_end,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] delta,
  output logic             meas_vld,
  output logic             meas_first
);
  logic [CNT_W-1:0] prev_q, prev_d;
  logic [CNT_W-1:0] delta_q, delta_d;
  logic             vld_q, vld_d;
  logic             first_q, first_d;
  logic             primed_q, primed_d;

  always_comb begin
    prev_d   = prev_q;
    delta_d  = delta_q;
    first_d  = first_q;
    primed_d = primed_q;
    vld_d    = win_end;
    if (win_end) begin
      delta_d  = cnt - prev_q;
      prev_d   = cnt;
      first_d  = !primed_q;
      primed_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      delta_q  <= '0;
      vld_q    <= 1'b0;
      first_q  <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= prev_d;
      delta_q  <= delta_d;
      vld_q    <= vld_d;
      first_q  <= first_d;
      primed_q <= primed_d;
    end
  end

  assign delta      = delta_q;
  assign meas_vld   = vld_q;
  assign meas_first = first_q;
endmodule

// File: rtl/fom_judge.sv
module fom_judge #(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned RATIO_W   = 4,
  parameter int unsigned WIN_LOG2  = 10,
  parameter int unsigned TOL_TIGHT = 2,
  parameter int unsigned TOL_LOOSE = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               meas_vld,
  input  logic               meas_first,
  input  logic [CNT_W-1:0]   delta,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               thr_tight,
  output logic               alarm
);
  localparam int unsigned CMP_W = CNT_W + 2;

  logic [CMP_W-1:0] nom_cnt, tol_cnt, got_cnt;
  logic             too_fast, too_slow, no_edges, bad_win;
  logic             alarm_q, alarm_d;
  logic             good_q, good_d;

  always_comb begin
    nom_cnt  = CMP_W'(ratio) << WIN_LOG2;
    tol_cnt  = CMP_W'(ratio) * (thr_tight ? CMP_W'(TOL_TIGHT) : CMP_W'(TOL_LOOSE));
    got_cnt  = CMP_W'(delta);
    too_fast = got_cnt > (nom_cnt + tol_cnt);
    too_slow = (got_cnt + tol_cnt) < nom_cnt;
    no_edges = (delta == '0);
    bad_win  = no_edges || (!meas_first && (too_fast || too_slow));
  end

  always_comb begin
    alarm_d = alarm_q;
    good_d  = good_q;
    if (meas_vld) begin
      if (bad_win) begin
        alarm_d = 1'b1;
        good_d  = 1'b0;
      end else if (!meas_first && alarm_q) begin
        if (good_q) begin
          alarm_d = 1'b0;
          good_d  = 1'b0;
        end else begin
          good_d  = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_q <= 1'b0;
      good_q  <= 1'b0;
    end else begin
      alarm_q <= alarm_d;
      good_q  <= good_d;
    end
  end

  assign alarm = alarm_q;
endmodule

// File: rtl/fom_monitor.sv
module fom_monitor #(
  parameter int unsigned NUM_MON     = 3,
  parameter int unsigned WIN_LOG2    = 20,
  parameter int unsigned RATIO_W     = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TOL_TIGHT   = fom_pkg::ppm_counts(WIN_LOG2, fom_pkg::TIGHT_PPM_X10),
  parameter int unsigned TOL_LOOSE   = fom_pkg::ppm_counts(WIN_LOG2, fom_pkg::LOOSE_PPM_X10)
) (
  input  logic                             rst_n,
  input  logic                             ref_clk,
  input  logic [NUM_MON-1:0]               mon_clk,
  input  logic [NUM_MON-1:0][RATIO_W-1:0]  ratio,
  input  logic                             thr_tight,
  output logic [NUM_MON-1:0]               alarm
);
  localparam int unsigned CNT_W = WIN_LOG2 + RATIO_W + 1;

  logic                            ref_rst_n;
  logic                            win_end;
  logic [NUM_MON-1:0]              mon_rst_n;
  logic [NUM_MON-1:0][CNT_W-1:0]   mon_gray;
  logic [NUM_MON-1:0][CNT_W-1:0]   mon_cnt;
  logic [NUM_MON-1:0][CNT_W-1:0]   delta;
  logic [NUM_MON-1:0]              meas_vld;
  logic [NUM_MON-1:0]              meas_first;

  fom_rst_sync #(.STAGES(SYNC_STAGES)) u_ref_rst (
    .clk(ref_clk), .arst_n(rst_n), .srst_n(ref_rst_n)
  );

  fom_window_gen #(.WIN_LOG2(WIN_LOG2)) u_win (
    .clk(ref_clk), .rst_n(ref_rst_n), .win_end(win_end)
  );

  for (genvar i = 0; i < NUM_MON; i++) begin : g_chan
    fom_rst_sync #(.STAGES(SYNC_STAGES)) u_mon_rst (
      .clk(mon_clk[i]), .arst_n(rst_n), .srst_n(mon_rst_n[i])
    );

    fom_gray_counter #(.W(CNT_W)) u_cnt (
      .clk(mon_clk[i]), .rst_n(mon_rst_n[i]), .gray(mon_gray[i])
    );

    fom_gray_sync #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(ref_clk), .rst_n(ref_rst_n), .gray_in(mon_gray[i]), .bin_out(mon_cnt[i])
    );

    fom_meas #(.CNT_W(CNT_W)) u_meas (
      .clk(ref_clk), .rst_n(ref_rst_n), .win_end(win_end), .cnt(mon_cnt[i]),
      .delta(delta[i]), .meas_vld(meas_vld[i]), .meas_first(meas_first[i])
    );

    fom_judge #(
      .CNT_W(CNT_W), .RATIO_W(RATIO_W), .WIN_LOG2(WIN_LOG2),
      .TOL_TIGHT(TOL_TIGHT), .TOL_LOOSE(TOL_LOOSE)
    ) u_judge (
      .clk(ref_clk), .rst_n(ref_rst_n), .meas_vld(meas_vld[i]),
      .meas_first(meas_first[i]), .delta(delta[i]), .ratio(ratio[i]),
      .thr_tight(thr_tight), .alarm(alarm[i])
    );
  end
endmodule

// File: rtl/fom_monitor_chk.sv
module fom_monitor_chk #(
  parameter int unsigned NUM_MON   = 3,
  parameter int unsigned WIN_LOG2  = 20,
  parameter int unsigned RATIO_W   = 4,
  parameter int unsigned CNT_W     = 25,
  parameter int unsigned TOL_LOOSE = 20
) (
  input logic                            ref_clk,
  input logic                            ref_rst_n,
  input logic [NUM_MON-1:0]              mon_clk,
  input logic [NUM_MON-1:0]              mon_rst_n,
  input logic [NUM_MON-1:0][CNT_W-1:0]   mon_gray,
  input logic                            win_end,
  input logic [NUM_MON-1:0]              meas_vld,
  input logic [NUM_MON-1:0]              meas_first,
  input logic [NUM_MON-1:0][CNT_W-1:0]   delta,
  input logic [NUM_MON-1:0][RATIO_W-1:0] ratio,
  input logic [NUM_MON-1:0]              alarm
);
  localparam int unsigned CW = CNT_W + RATIO_W + 8;

  logic [WIN_LOG2:0] gap_q;
  logic              seen_q;

  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (win_end) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  // R2: consecutive window ends are one full window apart
  p_window_len_r2: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    (win_end && seen_q) |-> (gap_q == (WIN_LOG2+1)'((1 << WIN_LOG2) - 1)));

  for (genvar i = 0; i < NUM_MON; i++) begin : g_chk
    // R11: Gray code moves by at most one bit per monitored edge
    p_gray_one_step_r11: assert property (@(posedge mon_clk[i]) disable iff (!mon_rst_n[i])
      $onehot0(mon_gray[i] ^ $past(mon_gray[i])));

    // R12: alarm holds unless a measurement was just delivered
    p_alarm_quiet_r12: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
      !$past(meas_vld[i]) |-> $stable(alarm[i]));

    // R9: a window with no monitored edges raises the alarm
    p_zero_sets_r9: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
      (meas_vld[i] && (delta[i] == '0)) |=> alarm[i]);

    // R4: exceeding the loose bound always raises the alarm
    p_loose_exceeded_r4: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
      (meas_vld[i] && !meas_first[i] &&
       (CW'(delta[i]) > ((CW'(ratio[i]) << WIN_LOG2) + CW'(ratio[i]) * CW'(TOL_LOOSE))))
      |=> alarm[i]);
  end
endmodule

bind fom_monitor fom_monitor_chk #(
  .NUM_MON(NUM_MON), .WIN_LOG2(WIN_LOG2), .RATIO_W(RATIO_W),
  .CNT_W(CNT_W), .TOL_LOOSE(TOL_LOOSE)
) u_chk (
  .ref_clk(ref_clk), .ref_rst_n(ref_rst_n), .mon_clk(mon_clk), .mon_rst_n(mon_rst_n),
  .mon_gray(mon_gray), .win_end(win_end), .meas_vld(meas_vld), .meas_first(meas_first),
  .delta(delta), .ratio(ratio), .alarm(alarm)
);

// File: tb/fom_monitor_test.sv
`timescale 1ns/1ps
module fom_monitor_test;
  localparam int WIN = 1024;

  logic             ref_clk = 1'b0;
  logic             rst_n;
  logic [2:0]       mclk;
  logic [2:0][3:0]  ratio;
  logic             thr_tight;
  logic [2:0]       alarm;

  real half_ns [3];
  bit  run [3];
  int  cyc = 0;
  int  checks = 0;
  int  errors = 0;
  int  first_rise = 0;
  bit  done = 1'b0;

  always #5 ref_clk = ~ref_clk;
  always @(posedge ref_clk) cyc <= cyc + 1;

  for (genvar g = 0; g < 3; g++) begin : g_clk
    logic c = 1'b0;
    always begin
      if (run[g]) begin
        #(half_ns[g]);
        c = ~c;
      end else begin
        c = 1'b0;
        #1;
      end
    end
    assign mclk[g] = c;
  end

  fom_monitor #(
    .NUM_MON(3), .WIN_LOG2(10), .RATIO_W(4), .SYNC_STAGES(2),
    .TOL_TIGHT(2), .TOL_LOOSE(8)
  ) uut (
    .rst_n(rst_n), .ref_clk(ref_clk), .mon_clk(mclk), .ratio(ratio),
    .thr_tight(thr_tight), .alarm(alarm)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_rate(input int ch, input int r, input int dev);
    ratio[ch]   = 4'(r);
    half_ns[ch] = 10240.0 / (2.0 * real'(r * WIN + dev));
    run[ch]     = 1'b1;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic wait_rise(input int ch, output int at);
    int t = 0;
    while (!alarm[ch] && t < 4 * WIN) begin
      @(negedge ref_clk);
      t++;
    end
    at = cyc;
  endtask

  task automatic t_reset();
    int t;
    int rel;
    rst_n = 1'b0;
    thr_tight = 1'b0;
    set_rate(0, 1, 0);
    set_rate(1, 2, 0);
    ratio[2] = 4'd3;
    half_ns[2] = 10240.0 / (2.0 * 3.0 * WIN);
    run[2] = 1'b0;
    wait_cyc(20);
    check(alarm == 3'b000, "R1 alarms during reset", int'(alarm), 0);
    @(negedge ref_clk);
    rst_n = 1'b1;
    rel = cyc;
    wait_cyc(500);
    check(alarm == 3'b000, "R1 alarms before first window", int'(alarm), 0);
    wait_rise(2, t);
    first_rise = t;
    check(alarm[2] && (t - rel) <= WIN + 16, "R9 stopped clock in first window", t - rel, WIN);
    check(alarm[1:0] == 2'b00, "R10 running channels untouched", int'(alarm[1:0]), 0);
  endtask

  task automatic t_nominal();
    set_rate(2, 3, 0);
    wait_cyc(4 * WIN);
    check(alarm == 3'b000, "R3 R11 nominal loose", int'(alarm), 0);
    thr_tight = 1'b1;
    wait_cyc(3 * WIN);
    check(alarm == 3'b000, "R3 nominal tight", int'(alarm), 0);
    thr_tight = 1'b0;
  endtask

  task automatic t_between_classes();
    set_rate(1, 2, 10);
    wait_cyc(4 * WIN);
    check(alarm == 3'b000, "R4 inside loose bound", int'(alarm), 0);
    thr_tight = 1'b1;
    wait_cyc(3 * WIN);
    check(alarm == 3'b010, "R5 R10 tight bound exceeded", int'(alarm), 2);
    thr_tight = 1'b0;
    set_rate(1, 2, 30);
    wait_cyc(4 * WIN);
    check(alarm == 3'b010, "R4 loose bound exceeded", int'(alarm), 2);
    set_rate(1, 2, 0);
    wait_cyc(4 * WIN);
    check(alarm == 3'b000, "R8 recovered after offset", int'(alarm), 0);
  endtask

  task automatic t_slow_input();
    set_rate(0, 1, -20);
    wait_cyc(3 * WIN);
    check(alarm == 3'b001, "R6 slow clock flagged", int'(alarm), 1);
    set_rate(0, 1, 0);
    wait_cyc(4 * WIN);
    check(alarm == 3'b000, "R6 slow clock recovered", int'(alarm), 0);
  endtask

  task automatic t_hysteresis();
    int c0;
    int t;
    c0 = cyc;
    set_rate(2, 3, 60);
    wait_rise(2, t);
    set_rate(2, 3, 0);
    check(alarm[2] && (t - c0) <= 2 * WIN + 8, "R7 set after one bad window", t - c0, 2 * WIN);
    wait_cyc(WIN + WIN / 2);
    check(alarm[2] == 1'b1, "R8 still set after one good window", int'(alarm[2]), 1);
    wait_cyc(WIN);
    check(alarm[2] == 1'b0, "R8 clear after two good windows", int'(alarm[2]), 0);
  endtask

  task automatic t_stopped_clock();
    int c0;
    int t;
    c0 = cyc;
    run[0] = 1'b0;
    wait_rise(0, t);
    check(alarm[0] && (t - c0) <= 2 * WIN + 8, "R9 stopped clock flagged", t - c0, 2 * WIN);
    check(((t - first_rise) % WIN) == 0, "R2 R12 rises on window grid", (t - first_rise) % WIN, 0);
    check(alarm[2:1] == 2'b00, "R10 others unaffected", int'(alarm[2:1]), 0);
    set_rate(0, 1, 0);
    wait_cyc(4 * WIN);
    check(alarm == 3'b000, "R8 restarted clock clears", int'(alarm), 0);
  endtask

  initial begin
    repeat (150000) @(posedge ref_clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_nominal();
    t_between_classes();
    t_slow_input();
    t_hysteresis();
    t_stopped_clock();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule